// File: doc/BRIEF.md
# Memory Protection Region Encoder

This block converts one requested protected memory region into entries of a small protection table. A request gives a byte start address, a byte length and a permission byte. The block keeps the next free slot index internally. It chooses the cheapest way to describe the region with the slots available and writes one or two slots. It then advances the index and reports success, or it reports failure when the table has no room.

The encoder tries three forms in a fixed order. The first is a top-of-range entry that reuses the address word already in the slot below as its lower bound. The second is a single naturally aligned power-of-two entry. The last is a two-slot pair: an inactive lower-bound slot followed by a top-of-range slot. The slot contents can be read back through a combinational read port, which is how the table is observed. Software is expected to keep start and length multiples of 4. A length of 0 stands for the entire address space.

Top module: `prot_region_encoder`

## Requirements
- R1: After reset every slot holds address word 0 and config byte 0, and `cur_idx` equals the parameter `IDX_BASE`.
- R2: `done` is high for exactly the one cycle after each cycle in which `req_go` is sampled high, and is low otherwise; `ok` is valid with `done` and low when `done` is low.
- R3: If the index is 0 and start is 0, or the index is nonzero and the address word of slot index-1 equals start>>2, slot index receives a top-of-range entry with address word (start+length)>>2.
- R4: Otherwise, if the length is a power of two and start is a multiple of it, slot index receives address word (start | ((length-1)>>1))>>2. Its mode is 4-byte (code 2) for length 4 and power-of-two (code 3) otherwise.
- R5: Otherwise slot index receives address word start>>2 with config byte 0. Slot index+1 receives a top-of-range entry with address word (start+length)>>2.
- R6: When the index is at or beyond `SLOTS`, the request fails: `ok` is 0, no slot changes and the index is kept.
- R7: When the two-slot form is needed and index+1 is at or beyond `SLOTS`, the request fails with no slot written and the index kept.
- R8: A length of 0 means 2^ADDR_W bytes. Start 0 with length 0 at index 0 gives a top-of-range entry with address word 2^(ADDR_W-2), which covers the whole address space.
- R9: The config byte is the request's bits 7, 2, 1, 0 (lock, execute, write, read) in place, with bits 6:3 of the request ignored. It carries the mode code in bits 4:3, where off=0, top-of-range=1, 4-byte=2 and power-of-two=3. An off slot has config byte 0.
- R10: A successful request advances `cur_idx` by 1 for the R3/R4 forms and by 2 for the R5 form, and the new value is visible in the same cycle as `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_go | input | 1 | One-cycle request strobe |
| req_base | input | ADDR_W | Region start byte address |
| req_len | input | ADDR_W | Region length in bytes, 0 means the full space |
| req_perm | input | 8 | Requested permission bits |
| done | output | 1 | Request completed, one-cycle pulse |
| ok | output | 1 | Request succeeded, valid with done |
| cur_idx | output | IDX_W | Next free slot index |
| rd_sel | input | SEL_W | Slot selected for readback |
| rd_word | output | ADDR_W-1 | Address word of the selected slot |
| rd_cfg | output | 8 | Config byte of the selected slot |

## Verification
The shared-bound form at a nonzero index is the hardest case to reach from the ports. It needs an earlier request to have left a top value in the slot just below, and the new start has to land exactly on that value. The sweep covers a grid of starts and lengths from a fresh reset, so the first request falls into each of the three forms. Every case then sends a second request whose start equals the first region's end, which reaches the shared-bound form after a pair or another top-of-range entry. Two fixed fill sequences drive the index up to the table limit to reach both failure conditions.

// File: rtl/prot_enc_pkg.sv
package prot_enc_pkg;

   typedef enum logic [1:0] {
      MODE_OFF   = 2'd0,
      MODE_TOR   = 2'd1,
      MODE_NA4   = 2'd2,
      MODE_NAPOT = 2'd3
   } match_mode_e;

   typedef enum logic [1:0] {
      PLAN_FAIL   = 2'd0,
      PLAN_SHARED = 2'd1,
      PLAN_SINGLE = 2'd2,
      PLAN_PAIR   = 2'd3
   } plan_e;

   localparam logic [7:0] PERM_KEEP = 8'h87;
   localparam int         MODE_LSB  = 3;

   function automatic logic [7:0] pack_cfg(input logic [7:0] perm,
                                           input match_mode_e mode);
      logic [7:0] c;
      c = perm & PERM_KEEP;
      c[MODE_LSB +: 2] = mode;
      return c;
   endfunction

endpackage

// File: rtl/region_planner.sv
module region_planner
   import prot_enc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int SLOTS  = 8,
   parameter int IDX_W  = 4,
   parameter int WORD_W = 31
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] len,
   input  logic [7:0]        perm,
   input  logic [IDX_W-1:0]  idx,
   input  logic [WORD_W-1:0] prev_word,
   output plan_e             plan,
   output logic [WORD_W-1:0] word_a,
   output logic [7:0]        cfg_a,
   output logic [WORD_W-1:0] word_b,
   output logic [7:0]        cfg_b
);
   localparam int SW = ADDR_W + 1;

   logic [SW-1:0]     span, base_x, top_x, span_m1, napot_x;
   logic [WORD_W-1:0] base_word, top_word, napot_word;
   logic [IDX_W:0]    idx_p1;
   logic              at_limit, pair_limit, shared, is_pow2, aligned, is_na4;

   always_comb begin
      span       = (len == '0) ? (SW'(1) << ADDR_W) : {1'b0, len};
      base_x     = {1'b0, base};
      top_x      = base_x + span;
      span_m1    = span - SW'(1);
      napot_x    = base_x | (span_m1 >> 1);
      base_word  = base_x[SW-1:2];
      top_word   = top_x[SW-1:2];
      napot_word = napot_x[SW-1:2];
      is_pow2    = (span & span_m1) == '0;
      aligned    = (base_x & span_m1) == '0;
      is_na4     = span == SW'(4);
      idx_p1     = {1'b0, idx} + (IDX_W+1)'(1);
      at_limit   = idx >= IDX_W'(SLOTS);
      pair_limit = idx_p1 >= (IDX_W+1)'(SLOTS);
      shared     = (idx == '0) ? (base == '0) : (prev_word == base_word);

      plan   = PLAN_FAIL;
      word_a = '0;
      cfg_a  = '0;
      word_b = top_word;
      cfg_b  = pack_cfg(perm, MODE_TOR);

      if (at_limit) begin
         plan = PLAN_FAIL;
      end else if (shared) begin
         plan   = PLAN_SHARED;
         word_a = top_word;
         cfg_a  = pack_cfg(perm, MODE_TOR);
      end else if (is_pow2 && aligned) begin
         plan   = PLAN_SINGLE;
         word_a = napot_word;
         cfg_a  = pack_cfg(perm, is_na4 ? MODE_NA4 : MODE_NAPOT);
      end else if (pair_limit) begin
         plan = PLAN_FAIL;
      end else begin
         plan   = PLAN_PAIR;
         word_a = base_word;
         cfg_a  = 8'h00;
      end
   end

endmodule

// File: rtl/slot_store.sv
module slot_store #(
   parameter int SLOTS  = 8,
   parameter int WORD_W = 31,
   parameter int SEL_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_a,
   input  logic [SEL_W-1:0]  sel_a,
   input  logic [WORD_W-1:0] word_a,
   input  logic [7:0]        cfg_a,
   input  logic              we_b,
   input  logic [SEL_W-1:0]  sel_b,
   input  logic [WORD_W-1:0] word_b,
   input  logic [7:0]        cfg_b,
   input  logic [SEL_W-1:0]  prev_sel,
   output logic [WORD_W-1:0] prev_word,
   input  logic [SEL_W-1:0]  rd_sel,
   output logic [WORD_W-1:0] rd_word,
   output logic [7:0]        rd_cfg
);
   logic [WORD_W-1:0] slot_word [SLOTS];
   logic [7:0]        slot_cfg  [SLOTS];

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      logic hit_a, hit_b;
      assign hit_a = we_a && (int'(sel_a) == g);
      assign hit_b = we_b && (int'(sel_b) == g);
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            slot_word[g] <= '0;
            slot_cfg[g]  <= '0;
         end else if (hit_a) begin
            slot_word[g] <= word_a;
            slot_cfg[g]  <= cfg_a;
         end else if (hit_b) begin
            slot_word[g] <= word_b;
            slot_cfg[g]  <= cfg_b;
         end
      end
   end

   always_comb begin
      prev_word = '0;
      rd_word   = '0;
      rd_cfg    = '0;
      for (int k = 0; k < SLOTS; k++) begin
         if (int'(prev_sel) == k) prev_word = slot_word[k];
         if (int'(rd_sel) == k) begin
            rd_word = slot_word[k];
            rd_cfg  = slot_cfg[k];
         end
      end
   end

endmodule

// File: rtl/prot_region_encoder.sv
module prot_region_encoder
   import prot_enc_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int SLOTS    = 8,
   parameter int IDX_BASE = 0,
   localparam int IDX_W   = $clog2(SLOTS + 1),
   localparam int SEL_W   = $clog2(SLOTS),
   localparam int WORD_W  = ADDR_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_go,
   input  logic [ADDR_W-1:0] req_base,
   input  logic [ADDR_W-1:0] req_len,
   input  logic [7:0]        req_perm,
   output logic              done,
   output logic              ok,
   output logic [IDX_W-1:0]  cur_idx,
   input  logic [SEL_W-1:0]  rd_sel,
   output logic [WORD_W-1:0] rd_word,
   output logic [7:0]        rd_cfg
);
   if (ADDR_W < 8) begin : g_bad_addr_w
      $error("prot_region_encoder: ADDR_W must be at least 8");
   end
   if (SLOTS < 2) begin : g_bad_slots
      $error("prot_region_encoder: SLOTS must be at least 2");
   end
   if (IDX_BASE < 0 || IDX_BASE > SLOTS) begin : g_bad_base
      $error("prot_region_encoder: IDX_BASE outside 0..SLOTS");
   end

   plan_e             plan;
   logic [WORD_W-1:0] word_a, word_b, prev_word;
   logic [7:0]        cfg_a, cfg_b;
   logic [IDX_W-1:0]  idx_q, advance;
   logic [SEL_W-1:0]  sel_a, sel_b, prev_sel;
   logic              we_a, we_b;

   region_planner #(
      .ADDR_W(ADDR_W), .SLOTS(SLOTS), .IDX_W(IDX_W), .WORD_W(WORD_W)
   ) u_plan (
      .base(req_base), .len(req_len), .perm(req_perm), .idx(idx_q),
      .prev_word(prev_word), .plan(plan),
      .word_a(word_a), .cfg_a(cfg_a), .word_b(word_b), .cfg_b(cfg_b)
   );

   always_comb begin
      sel_a    = idx_q[SEL_W-1:0];
      sel_b    = sel_a + SEL_W'(1);
      prev_sel = sel_a - SEL_W'(1);
      we_a     = req_go && (plan != PLAN_FAIL);
      we_b     = req_go && (plan == PLAN_PAIR);
      unique case (plan)
         PLAN_PAIR:               advance = IDX_W'(2);
         PLAN_SHARED, PLAN_SINGLE: advance = IDX_W'(1);
         default:                 advance = '0;
      endcase
   end

   slot_store #(
      .SLOTS(SLOTS), .WORD_W(WORD_W), .SEL_W(SEL_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .we_a(we_a), .sel_a(sel_a), .word_a(word_a), .cfg_a(cfg_a),
      .we_b(we_b), .sel_b(sel_b), .word_b(word_b), .cfg_b(cfg_b),
      .prev_sel(prev_sel), .prev_word(prev_word),
      .rd_sel(rd_sel), .rd_word(rd_word), .rd_cfg(rd_cfg)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q <= IDX_W'(IDX_BASE);
         done  <= 1'b0;
         ok    <= 1'b0;
      end else begin
         done <= req_go;
         ok   <= we_a;
         if (req_go) idx_q <= idx_q + advance;
      end
   end

   assign cur_idx = idx_q;

endmodule

// File: rtl/prot_region_encoder_chk.sv
module prot_region_encoder_chk #(
   parameter int SLOTS = 8,
   parameter int IDX_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_go,
   input logic             done,
   input logic             ok,
   input logic [IDX_W-1:0] cur_idx
);
   // R2: done follows each strobe by one cycle
   a_r2_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_go |=> done);
   // R2: no done without a strobe
   a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !req_go |=> !done);
   // R2: ok only with done
   a_r2_ok_gated: assert property (@(posedge clk) disable iff (!rst_n)
      ok |-> done);
   // R6: a failed request keeps the index
   a_r6_fail_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !ok) |-> $stable(cur_idx));
   // R6: the index never passes the table size
   a_r6_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cur_idx) <= SLOTS);
   // R7: failure only happens near the table end
   a_r7_fail_near_end: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !ok) |-> (int'($past(cur_idx)) + 1 >= SLOTS));
   // R10: success advances by one or two
   a_r10_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (done && ok) |-> ((int'(cur_idx) == int'($past(cur_idx)) + 1) ||
                        (int'(cur_idx) == int'($past(cur_idx)) + 2)));
endmodule

bind prot_region_encoder prot_region_encoder_chk #(
   .SLOTS(SLOTS), .IDX_W(IDX_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_go(req_go),
   .done(done), .ok(ok), .cur_idx(cur_idx)
);

// File: tb/prot_region_encoder_bench.sv
module prot_region_encoder_bench;
   localparam int AW     = 12;
   localparam int NSLOT  = 4;
   localparam int IDXW   = $clog2(NSLOT + 1);
   localparam int SELW   = $clog2(NSLOT);
   localparam int WORDW  = AW - 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_go = 1'b0;
   logic [AW-1:0]    req_base = '0;
   logic [AW-1:0]    req_len = '0;
   logic [7:0]       req_perm = '0;
   logic             done, ok;
   logic [IDXW-1:0]  cur_idx;
   logic [SELW-1:0]  rd_sel = '0;
   logic [WORDW-1:0] rd_word;
   logic [7:0]       rd_cfg;

   int checks = 0;
   int fails  = 0;
   int mw [NSLOT];
   int mc [NSLOT];
   int midx;

   always #10 clk = ~clk;

   prot_region_encoder #(.ADDR_W(AW), .SLOTS(NSLOT), .IDX_BASE(0)) u_prot_region_encoder (
      .clk(clk), .rst_n(rst_n), .req_go(req_go), .req_base(req_base),
      .req_len(req_len), .req_perm(req_perm), .done(done), .ok(ok),
      .cur_idx(cur_idx), .rd_sel(rd_sel), .rd_word(rd_word), .rd_cfg(rd_cfg)
   );

   task automatic chk(input bit good, input string what, input int act, input int exp);
      checks++;
      if (!good) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   task automatic chk_slots(input string tag);
      for (int k = 0; k < NSLOT; k++) begin
         rd_sel = SELW'(k);
         #1;
         chk(int'(rd_word) == mw[k], {tag, " slot word"}, int'(rd_word), mw[k]);
         chk(int'(rd_cfg) == mc[k], {"R9 cfg byte / ", tag}, int'(rd_cfg), mc[k]);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      req_go = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      midx = 0;
      for (int k = 0; k < NSLOT; k++) begin
         mw[k] = 0;
         mc[k] = 0;
      end
      chk(int'(cur_idx) == 0, "R1 reset index", int'(cur_idx), 0);
      chk(done == 1'b0, "R1 reset done", int'(done), 0);
      chk_slots("R1 reset");
   endtask

   task automatic do_req(input int s, input int l, input int p);
      int    full, pm, eok, top;
      string tag;
      full = (l == 0) ? (1 << AW) : l;
      pm   = p & 'h87;
      top  = (s + full) >> 2;
      eok  = 1;
      if (midx >= NSLOT) begin
         tag = "R6 at limit";
         eok = 0;
      end else if ((midx == 0 && s == 0) || (midx != 0 && mw[midx-1] == (s >> 2))) begin
         tag = (midx == 0 && s == 0 && l == 0) ? "R8 whole space" : "R3 shared top";
         mw[midx] = top;
         mc[midx] = pm | (1 << 3);
         midx = midx + 1;
      end else if ((full & (full - 1)) == 0 && (s & (full - 1)) == 0) begin
         tag = "R4 single";
         mw[midx] = (s | ((full - 1) >> 1)) >> 2;
         mc[midx] = pm | (((full == 4) ? 2 : 3) << 3);
         midx = midx + 1;
      end else if (midx + 1 >= NSLOT) begin
         tag = "R7 pair at limit";
         eok = 0;
      end else begin
         tag = "R5 pair";
         mw[midx]   = s >> 2;
         mc[midx]   = 0;
         mw[midx+1] = top;
         mc[midx+1] = pm | (1 << 3);
         midx = midx + 2;
      end
      @(negedge clk);
      req_go   = 1'b1;
      req_base = AW'(s);
      req_len  = AW'(l);
      req_perm = 8'(p);
      @(posedge clk);
      @(negedge clk);
      req_go = 1'b0;
      chk(done == 1'b1, "R2 done pulse", int'(done), 1);
      chk(int'(ok) == eok, {tag, " status"}, int'(ok), eok);
      chk(int'(cur_idx) == midx, {"R10 index / ", tag}, int'(cur_idx), midx);
      chk_slots(tag);
      @(negedge clk);
      chk(done == 1'b0, "R2 done single cycle", int'(done), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      do_reset();
      do_req(0, 0, 'hff);
      for (int s = 0; s < 256; s += 4) begin
         for (int l = 0; l <= 64; l += 4) begin
            do_reset();
            do_req(s, l, (s * 7 + l) & 255);
            if (l != 0) do_req(s + l, 8, 3);
            else        do_req(256, 8, 3);
         end
      end
      // R6 fill with pairs
      do_reset();
      do_req(4, 8, 'h07);
      do_req(100, 12, 'h01);
      do_req(512, 64, 'h01);
      // R7 pair at the last slot, then R4 fills it, then R6
      do_reset();
      do_req(0, 16, 'h03);
      do_req(40, 12, 'h05);
      do_req(200, 12, 'h01);
      do_req(512, 64, 'h81);
      do_req(1024, 4, 'h01);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule